// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is a two-operand integer arithmetic and logic unit that computes a result together with six condition flags: carry, parity, auxiliary carry, zero, sign and overflow. The flags follow the rules of a classic PC-style processor. Carry is taken out of the top bit of the chosen size and acts as a borrow on subtraction. Auxiliary carry is the carry (or borrow) between the low two nibbles. Parity looks only at the low byte. The add-with-carry and subtract-with-borrow operations consume an incoming carry flag.

Each operation works on 8, 16 or 32 bits, picked per operation by a size select. Operand bits above the chosen size are ignored, and result bits above it come out as zero. Next to the flags the block emits an update mask. The mask tells the surrounding flag register which flag bits the operation writes. The core is combinational. A parameter selects whether the result, flags, mask and valid pass through one output register stage or straight to the ports.

Top module: `alu_flags_unit`

## Requirements
- R1: Opcode encoding: 0 add A+B, 1 add-with-carry A+B+carryIn, 2 increment A+1, 3 subtract A-B, 4 subtract-with-borrow A-B-carryIn, 5 decrement A-1, 6 negate 0-A, 7 AND, 8 OR, 9 XOR, 10 NOT of A. For the arithmetic codes 0 to 6, the result is the value of the selected size, taken modulo 2^size.
- R2: Codes 7 to 10 return the bitwise result of the selected size.
- R3: sizeSel selects the size: 0 gives 8 bits, 1 gives 16 bits, 2 and 3 give 32 bits. Operand bits above the size have no effect on the result or the flags, and result bits above the size are zero.
- R4: Flag bit positions are flags[0] carry, flags[1] parity, flags[2] auxiliary carry, flags[3] zero, flags[4] sign and flags[5] overflow. Zero is set when the sized result is 0. Sign equals the result bit at the top of the selected size. Parity is set when result bits 7:0 hold an even number of ones, whatever the size.
- R5: On add-type codes, carry is the carry out of the top bit of the selected size. On subtract-type codes, it is the borrow. Increment and decrement copy carryIn to the carry output. Negate sets carry exactly when the sized operand A is nonzero.
- R6: Auxiliary carry is the carry out of bit 3 for add-type codes and the borrow out of bit 3 for subtract, decrement and negate.
- R7: Overflow is set when the signed result of an arithmetic code falls outside the signed range of the selected size.
- R8: Add-with-carry adds carryIn, and subtract-with-borrow also subtracts carryIn. The other codes ignore carryIn, except where R5 copies it.
- R9: Codes 7 to 10 drive carry, overflow and auxiliary carry to 0. They set zero, sign and parity from the result.
- R10: flagMask uses the same bit positions as flags. Codes 0, 1, 3, 4 and 6 give 0x3F. Codes 2 and 5 give 0x3E. Codes 7, 8 and 9 give 0x3B. Code 10 gives 0x00. Codes 11 to 15 give a zero result and a 0x00 mask.
- R11: With REG_OUT=1, the results of an operation presented with inValid appear one clock later with outValid high. During reset, outValid, result, flags and flagMask are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | The operands and opcode on the inputs are valid |
| opA | input | DATA_W | First operand |
| opB | input | DATA_W | Second operand |
| opcode | input | 4 | Operation code (R1) |
| sizeSel | input | 2 | Operand size select (R3) |
| carryIn | input | 1 | Incoming carry flag |
| outValid | output | 1 | result, flags and flagMask are valid |
| result | output | DATA_W | Sized result, upper bits zero |
| flags | output | 6 | Status flags (R4) |
| flagMask | output | 6 | Flags written by this operation (R10) |

## Verification
The bench builds the unit with DATA_W=32 and REG_OUT=1, so all three sizes can be reached and the one-cycle output stage with its valid bit is exercised. Directed vectors cover the overflow, carry and borrow edges at each size: 0x7F+1, 0xFF+1, 0-1, and negating zero and the most negative value. A pseudo-random sweep with the upper operand bits filled covers every opcode at every size, including the unused codes.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  localparam int FLAG_N = 6;
  localparam int FL_CARRY = 0;
  localparam int FL_PARITY = 1;
  localparam int FL_AUX = 2;
  localparam int FL_ZERO = 3;
  localparam int FL_SIGN = 4;
  localparam int FL_OVER = 5;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_INC = 4'd2,
    OP_SUB = 4'd3,
    OP_SBB = 4'd4,
    OP_DEC = 4'd5,
    OP_NEG = 4'd6,
    OP_AND = 4'd7,
    OP_OR  = 4'd8,
    OP_XOR = 4'd9,
    OP_NOT = 4'd10
  } opcode_e;

  typedef enum logic [2:0] {
    LOG_AND,
    LOG_OR,
    LOG_XOR,
    LOG_NOT,
    LOG_ZERO
  } logSel_e;

  typedef struct packed {
    logic isArith;
    logic isSub;
    logic useZeroA;
    logic bIsOne;
    logic invertB;
    logic cinFromFlag;
    logic cinConst;
    logic keepCarry;
    logSel_e logSel;
    logic [FLAG_N-1:0] updMask;
  } ctrl_t;

  localparam logic [FLAG_N-1:0] MASK_ARITH = 6'h3F;
  localparam logic [FLAG_N-1:0] MASK_STEP = 6'h3E;
  localparam logic [FLAG_N-1:0] MASK_LOGIC = 6'h3B;

endpackage

// File: rtl/alu_flags_ctrl.sv
module alu_flags_ctrl
  import alu_flags_pkg::*;
(
  input  logic [3:0] opcode,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '{isArith: 1'b0, isSub: 1'b0, useZeroA: 1'b0, bIsOne: 1'b0,
             invertB: 1'b0, cinFromFlag: 1'b0, cinConst: 1'b0,
             keepCarry: 1'b0, logSel: LOG_ZERO, updMask: '0};
    case (opcode)
      OP_ADD: begin
        ctrl.isArith = 1'b1;
        ctrl.updMask = MASK_ARITH;
      end
      OP_ADC: begin
        ctrl.isArith = 1'b1;
        ctrl.cinFromFlag = 1'b1;
        ctrl.updMask = MASK_ARITH;
      end
      OP_INC: begin
        ctrl.isArith = 1'b1;
        ctrl.bIsOne = 1'b1;
        ctrl.keepCarry = 1'b1;
        ctrl.updMask = MASK_STEP;
      end
      OP_SUB: begin
        ctrl.isArith = 1'b1;
        ctrl.isSub = 1'b1;
        ctrl.invertB = 1'b1;
        ctrl.cinConst = 1'b1;
        ctrl.updMask = MASK_ARITH;
      end
      OP_SBB: begin
        ctrl.isArith = 1'b1;
        ctrl.isSub = 1'b1;
        ctrl.invertB = 1'b1;
        ctrl.cinFromFlag = 1'b1;
        ctrl.updMask = MASK_ARITH;
      end
      OP_DEC: begin
        ctrl.isArith = 1'b1;
        ctrl.isSub = 1'b1;
        ctrl.bIsOne = 1'b1;
        ctrl.invertB = 1'b1;
        ctrl.cinConst = 1'b1;
        ctrl.keepCarry = 1'b1;
        ctrl.updMask = MASK_STEP;
      end
      OP_NEG: begin
        ctrl.isArith = 1'b1;
        ctrl.isSub = 1'b1;
        ctrl.useZeroA = 1'b1;
        ctrl.invertB = 1'b1;
        ctrl.cinConst = 1'b1;
        ctrl.updMask = MASK_ARITH;
      end
      OP_AND: begin
        ctrl.logSel = LOG_AND;
        ctrl.updMask = MASK_LOGIC;
      end
      OP_OR: begin
        ctrl.logSel = LOG_OR;
        ctrl.updMask = MASK_LOGIC;
      end
      OP_XOR: begin
        ctrl.logSel = LOG_XOR;
        ctrl.updMask = MASK_LOGIC;
      end
      OP_NOT: begin
        ctrl.logSel = LOG_NOT;
      end
      default: begin
        ctrl.logSel = LOG_ZERO;
      end
    endcase
  end

endmodule

// File: rtl/alu_flags_datapath.sv
module alu_flags_datapath
  import alu_flags_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  ctrl_t              ctrl,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [1:0]         sizeSel,
  input  logic               carryIn,
  output logic [DATA_W-1:0]  result,
  output logic [FLAG_N-1:0]  flags
);

  localparam int SUM_W = DATA_W + 1;
  localparam int IDX_W = $clog2(DATA_W + 1);

  logic [IDX_W-1:0] wIdx;
  logic [IDX_W-1:0] msbIdx;
  logic [SUM_W-1:0] sizeMask;
  logic [SUM_W-1:0] aM, bM, aE, bPre, bAdd, sum, addRes, logRes, resX;
  logic             cinBit, coutBit, msbCarryIn;

  always_comb begin
    case (sizeSel)
      2'd0:    wIdx = IDX_W'(8);
      2'd1:    wIdx = IDX_W'(16);
      default: wIdx = IDX_W'(DATA_W);
    endcase
    msbIdx = wIdx - IDX_W'(1);
    sizeMask = (SUM_W'(1) << wIdx) - SUM_W'(1);
  end

  // Operand shaping: negate uses zero as the minuend and A as subtrahend.
  always_comb begin
    aM = {1'b0, opA} & sizeMask;
    bM = {1'b0, opB} & sizeMask;
    aE = ctrl.useZeroA ? '0 : aM;
    if (ctrl.bIsOne) bPre = SUM_W'(1);
    else if (ctrl.useZeroA) bPre = aM;
    else bPre = bM;
    bAdd = (ctrl.invertB ? ~bPre : bPre) & sizeMask;
    cinBit = ctrl.cinFromFlag ? (carryIn ^ ctrl.isSub) : ctrl.cinConst;
  end

  always_comb begin
    sum = aE + bAdd + SUM_W'(cinBit);
    addRes = sum & sizeMask;
    coutBit = sum[wIdx];
    msbCarryIn = aE[msbIdx] ^ bAdd[msbIdx] ^ addRes[msbIdx];
  end

  always_comb begin
    case (ctrl.logSel)
      LOG_AND: logRes = aM & bM;
      LOG_OR:  logRes = aM | bM;
      LOG_XOR: logRes = aM ^ bM;
      LOG_NOT: logRes = ~aM & sizeMask;
      default: logRes = '0;
    endcase
  end

  always_comb begin
    resX = ctrl.isArith ? addRes : logRes;
    result = resX[DATA_W-1:0];
    flags = '0;
    flags[FL_ZERO] = (resX == '0);
    flags[FL_SIGN] = resX[msbIdx];
    flags[FL_PARITY] = ~^resX[7:0];
    if (ctrl.isArith) begin
      flags[FL_CARRY] = ctrl.keepCarry ? carryIn : (coutBit ^ ctrl.isSub);
      flags[FL_AUX] = aE[4] ^ bPre[4] ^ addRes[4];
      flags[FL_OVER] = msbCarryIn ^ coutBit;
    end
  end

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flags_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [3:0]        opcode,
  input  logic [1:0]        sizeSel,
  input  logic              carryIn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic [5:0]        flags,
  output logic [5:0]        flagMask
);

  ctrl_t             ctrl;
  logic [DATA_W-1:0] dpResult;
  logic [FLAG_N-1:0] dpFlags;

  alu_flags_ctrl i_ctrl (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  alu_flags_datapath #(.DATA_W(DATA_W)) i_dp (
    .ctrl    (ctrl),
    .opA     (opA),
    .opB     (opB),
    .sizeSel (sizeSel),
    .carryIn (carryIn),
    .result  (dpResult),
    .flags   (dpFlags)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          outValid <= 1'b0;
          result <= '0;
          flags <= '0;
          flagMask <= '0;
        end else begin
          outValid <= inValid;
          if (inValid) begin
            result <= dpResult;
            flags <= dpFlags;
            flagMask <= ctrl.updMask;
          end
        end
      end

      assert_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
        1'b1 |=> outValid == $past(inValid));
      assert_result_capture_R11: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> result == $past(dpResult));
    end else begin : g_comb
      always_comb begin
        outValid = inValid;
        result = dpResult;
        flags = dpFlags;
        flagMask = ctrl.updMask;
      end
    end
  endgenerate

  assert_logic_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode >= 4'd7 && opcode <= 4'd10)
      |-> (!dpFlags[FL_CARRY] && !dpFlags[FL_OVER] && !dpFlags[FL_AUX]));
  assert_keep_carry_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opcode == 4'd2 || opcode == 4'd5)) |-> dpFlags[FL_CARRY] == carryIn);
  assert_zero_even_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && dpFlags[FL_ZERO]) |-> (dpFlags[FL_PARITY] && !dpFlags[FL_SIGN]));
  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sizeSel == 2'd0) |-> dpResult[DATA_W-1:8] == '0);
  assert_unused_code_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode > 4'd10) |-> (ctrl.updMask == '0 && dpResult == '0));

endmodule

// File: tb/test_alu_flags_unit.sv
module test_alu_flags_unit;

  localparam int DATA_W = 32;

  typedef struct {
    logic [31:0] res;
    logic [5:0]  flg;
    logic [5:0]  msk;
    bit          cmpFlags;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [3:0] opcode = '0;
  logic [1:0] sizeSel = '0;
  logic carryIn = 1'b0;
  logic outValid;
  logic [31:0] result;
  logic [5:0] flags, flagMask;

  int total = 0;
  int bad = 0;
  item_t expQ[$];

  always #10 clk = ~clk;

  alu_flags_unit #(.DATA_W(DATA_W), .REG_OUT(1'b1)) i_alu_flags_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .opcode(opcode), .sizeSel(sizeSel), .carryIn(carryIn),
    .outValid(outValid), .result(result), .flags(flags), .flagMask(flagMask)
  );

  function automatic longint sext(logic [63:0] v, int w);
    return v[w-1] ? longint'(v) - (longint'(1) << w) : longint'(v);
  endfunction

  function automatic item_t model(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                                  logic [1:0] sz, logic cin);
    item_t it;
    int w;
    logic [63:0] m, ua, ub, x, y, c, full, r;
    longint sr, lim;
    bit sub, arith;
    logic cf, af, of;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m = (64'd1 << w) - 64'd1;
    ua = {32'd0, a} & m;
    ub = {32'd0, b} & m;
    x = ua; y = ub; c = 0; sub = 0; arith = 1; cf = 0; af = 0; of = 0;
    it.cmpFlags = 1;
    case (op)
      4'd0: begin it.msk = 6'h3F; it.tag = "R1/R7"; end
      4'd1: begin c = {63'd0, cin}; it.msk = 6'h3F; it.tag = "R8"; end
      4'd2: begin y = 1; it.msk = 6'h3E; it.tag = "R5"; end
      4'd3: begin sub = 1; it.msk = 6'h3F; it.tag = "R1/R6"; end
      4'd4: begin sub = 1; c = {63'd0, cin}; it.msk = 6'h3F; it.tag = "R8"; end
      4'd5: begin sub = 1; y = 1; it.msk = 6'h3E; it.tag = "R5"; end
      4'd6: begin sub = 1; x = 0; y = ua; it.msk = 6'h3F; it.tag = "R5/R7"; end
      default: begin arith = 0; it.tag = "R2/R9"; end
    endcase
    if (arith) begin
      if (!sub) begin
        full = x + y + c;
        cf = full[w];
        af = ((x & 15) + (y & 15) + c) > 15;
        sr = sext(x, w) + sext(y, w) + longint'(c);
      end else begin
        full = x - y - c;
        cf = x < (y + c);
        af = (x & 15) < ((y & 15) + c);
        sr = sext(x, w) - sext(y, w) - longint'(c);
      end
      lim = longint'(1) << (w - 1);
      of = (sr >= lim) || (sr < -lim);
      if (op == 4'd2 || op == 4'd5) cf = cin;
      r = full & m;
    end else begin
      case (op)
        4'd7: begin r = ua & ub; it.msk = 6'h3B; end
        4'd8: begin r = ua | ub; it.msk = 6'h3B; end
        4'd9: begin r = ua ^ ub; it.msk = 6'h3B; end
        4'd10: begin r = ~ua & m; it.msk = 6'h00; end
        default: begin r = 0; it.msk = 6'h00; it.cmpFlags = 0; it.tag = "R10"; end
      endcase
    end
    it.res = r[31:0];
    it.flg[0] = cf;
    it.flg[1] = ~^r[7:0];
    it.flg[2] = af;
    it.flg[3] = (r == 0);
    it.flg[4] = r[w-1];
    it.flg[5] = of;
    return it;
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                       logic [1:0] sz, logic cin, string tagOverride = "");
    item_t it;
    it = model(op, a, b, sz, cin);
    if (tagOverride != "") it.tag = tagOverride;
    @(negedge clk);
    opcode = op; opA = a; opB = b; sizeSel = sz; carryIn = cin; inValid = 1'b1;
    expQ.push_back(it);
  endtask

  // Monitor: outputs settle after a posedge; compare at the following negedge.
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R11", "unexpected outValid", 64'd1, 64'd0);
      end else begin
        item_t it;
        it = expQ.pop_front();
        check(result == it.res, it.tag, "result", {32'd0, result}, {32'd0, it.res});
        check(flagMask == it.msk, "R10", "flagMask", {58'd0, flagMask}, {58'd0, it.msk});
        if (it.cmpFlags)
          check(flags == it.flg, it.tag, "flags", {58'd0, flags}, {58'd0, it.flg});
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(1'b0, "R11", "watchdog expired", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] lfsr;
    lfsr = 32'hACE1_2024;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(outValid == 1'b0 && result == '0 && flags == '0 && flagMask == '0,
          "R11", "reset state", {58'd0, flags}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R11", "idle after reset", {63'd0, outValid}, 64'd0);

    drive(4'd0, 32'h7F, 32'h01, 2'd0, 1'b0, "R7");          // 0x80, OF AF SF
    drive(4'd0, 32'hFF, 32'h01, 2'd0, 1'b0, "R5");          // 0, CF ZF AF PF
    drive(4'd1, 32'hFFFF, 32'h0, 2'd1, 1'b1, "R8");         // 0, CF
    drive(4'd3, 32'h0, 32'h1, 2'd2, 1'b0, "R5");            // all ones, borrow
    drive(4'd4, 32'h10, 32'h0F, 2'd0, 1'b1, "R6");          // 0, AF borrow
    drive(4'd2, 32'h7FFF, 32'h0, 2'd1, 1'b1, "R5");         // 0x8000, OF, carry held
    drive(4'd5, 32'h00, 32'h0, 2'd0, 1'b0, "R5");           // 0xFF, carry held 0
    drive(4'd6, 32'h0, 32'h0, 2'd0, 1'b1, "R5");            // 0, CF clear
    drive(4'd6, 32'h8000_0000, 32'h0, 2'd2, 1'b0, "R7");    // same, OF CF
    drive(4'd0, 32'hFFFF_FF01, 32'hAB00_0001, 2'd0, 1'b0, "R3"); // upper bits ignored
    drive(4'd7, 32'hF0F0_1234, 32'h0FF0_00FF, 2'd3, 1'b1, "R2");
    drive(4'd8, 32'h1200, 32'h0034, 2'd1, 1'b1, "R9");
    drive(4'd9, 32'hAA, 32'hAA, 2'd0, 1'b1, "R4");          // zero, even parity
    drive(4'd10, 32'hFFFF_FF0F, 32'h0, 2'd0, 1'b1, "R10");  // NOT, empty mask
    drive(4'd13, 32'h1234, 32'h5678, 2'd2, 1'b1, "R10");    // unused code
    @(negedge clk);
    inValid = 1'b0;

    // Sweep: every opcode at every size, upper operand bits populated.
    for (int k = 0; k < 640; k++) begin
      logic [31:0] a, b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = (k % 7 == 0) ? a : lfsr;
      drive(4'(k % 16), a, b, 2'(k / 16), lfsr[5]);
    end
    @(negedge clk);
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R11", "all results delivered", 64'(expQ.size()), 64'd0);
    check(outValid == 1'b0, "R11", "valid drops when idle", {63'd0, outValid}, 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule